// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

This block is a synthesizable model of a single-port synchronous SRAM with an internal 2-bit burst sequencer. The address, write data, chip selects, two load strobes, the advance input and the write controls are all captured on the rising clock edge. A load strobe starts an access at the external address. Later cycles either step the burst counter when advance is asserted or repeat the current address. The counter walks the two low address bits in linear or interleaved order. A new external address may be loaded on every cycle.

Read data leaves the array either directly (flow-through) or through one output register (pipelined). Writes update any subset of the byte lanes, and a global write stores the whole word. A tri-state bus is modelled as a data output and a separate drive flag. Output enable and sleep act on the drive flag without waiting for a clock edge. The word width is 18, 32 or 36 bits. An 18-bit word has two 9-bit lanes, a 32-bit word has four 8-bit lanes and a 36-bit word has four 9-bit lanes.

Top module: `sync_burst_sram`

## Requirements
- R1: While `rst_n` is low and after it is released, with no access started, `drive_o` is 0 and `dout_o` is all zeros.
- R2: A load strobe with the chip selected (`cs1_n_i`=0, `cs2_i`=1, `cs3_n_i`=0) loads `addr_i` as the access address, and a fresh address is accepted on every cycle. A `strb_b_n_i` strobe that arrives while the chip is not selected ends the session, and later idle cycles issue no access.
- R3: `strb_a_n_i` counts only when `cs1_n_i` is 0. It always starts a read, ignores the write controls, and has priority over `strb_b_n_i`. `strb_b_n_i` starts a read, or starts a write when the write controls request one.
- R4: In a cycle with no strobe during an open session, `adv_n_i`=0 steps the 2-bit burst counter and `adv_n_i`=1 repeats the current address. Address bits above bit 1 never change inside a burst.
- R5: With `linear_i`=1, the low two address bits of burst beat n are (start + n) mod 4.
- R6: With `linear_i`=0, the low two address bits of burst beat n are start XOR n.
- R7: With `pipe_mode_i`=0, read data for an access captured at edge e is driven right after edge e.
- R8: With `pipe_mode_i`=1, read data for an access captured at edge e is driven after edge e+1 and not after edge e.
- R9: A deselect turns `drive_o` off right after its capture edge in flow-through mode. In pipelined mode the read captured just before the deselect is still shown after the deselect's capture edge, and `drive_o` goes off after the next edge.
- R10: With `bwr_n_i`=0, only the lanes whose `lane_sel_n_i` bit is 0 are written. Lane i holds data bits [i*W +: W], where W is 9 for 36- and 18-bit words and 8 for 32-bit words. With no lane selected, or with `bwr_n_i`=1, no write happens.
- R11: `gwr_n_i`=0 writes every lane, whatever `bwr_n_i` and `lane_sel_n_i` are.
- R12: While a write access sits in the input stage, `drive_o` is 0 in both output modes.
- R13: `oe_n_i`=1 forces `drive_o` to 0 and `dout_o` to zero at once, with no clock edge needed.
- R14: While `sleep_i` is 1, `drive_o` is 0 and no access is captured. Strobes and writes are ignored, the memory keeps its contents and the burst session resumes when sleep ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| addr_i | input | ADDR_W | External word address |
| wdata_i | input | DATA_W | Write data, captured with the access |
| strb_a_n_i | input | 1 | Load strobe A, read-only, gated by cs1_n_i |
| strb_b_n_i | input | 1 | Load strobe B, read or write |
| adv_n_i | input | 1 | Burst advance, active low |
| cs1_n_i | input | 1 | Chip select, active low |
| cs2_i | input | 1 | Chip select, active high |
| cs3_n_i | input | 1 | Chip select, active low |
| gwr_n_i | input | 1 | Global (all-lane) write, active low |
| bwr_n_i | input | 1 | Lane write enable, active low |
| lane_sel_n_i | input | LANES | Per-lane write select, active low |
| oe_n_i | input | 1 | Output enable, active low, asynchronous |
| sleep_i | input | 1 | Low-power hold, active high, asynchronous |
| pipe_mode_i | input | 1 | 1 = pipelined read, 0 = flow-through |
| linear_i | input | 1 | 1 = linear burst order, 0 = interleaved |
| dout_o | output | DATA_W | Read data, zero when not driven |
| drive_o | output | 1 | Output bus drive flag |

## Verification
The bench builds the block with DATA_W=36 and ADDR_W=4, which gives 16 words in four 9-bit lanes. With so few words it can fill and read back every address in both output modes. It can also run every start offset through both burst orders in both modes, and try all sixteen lane masks on one word. It computes the burst sequences as modulo-4 sums and bitwise XORs, and it keeps expected memory contents in its own array. It times the corner cases at each edge: the deselect tail, a write following a read, strobe priority, ignored strobes and sleep.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
package sbs_pkg;

  // Low two address bits of burst beat 'step' from offset 'start'.
  function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                              input logic [1:0] step,
                                              input logic       linear);
    logic [1:0] res;
    if (linear) res = start + step;
    else        res = start ^ step;
    return res;
  endfunction

  // Lane count for a supported word width.
  function automatic int lane_count(input int data_w);
    return (data_w == 18) ? 2 : 4;
  endfunction

endpackage

// File: rtl/sbs_burst_ctrl.sv
`timescale 1ns/1ps
module sbs_burst_ctrl #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              strb_a_n_i,
  input  logic              strb_b_n_i,
  input  logic              adv_n_i,
  input  logic              cs1_n_i,
  input  logic              cs2_i,
  input  logic              cs3_n_i,
  input  logic              gwr_n_i,
  input  logic              bwr_n_i,
  input  logic [LANES-1:0]  lane_sel_n_i,
  input  logic              linear_i,
  output logic              acc_vld_o,
  output logic              acc_wr_o,
  output logic              acc_desel_o,
  output logic              acc_adv_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [LANES-1:0]  acc_mask_o,
  output logic [DATA_W-1:0] acc_wdata_o
);
  import sbs_pkg::*;

  logic              active_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;

  logic             selected;
  logic             start_a;
  logic             start_b;
  logic             start_any;
  logic [LANES-1:0] wr_mask;
  logic             wr_req;
  logic [1:0]       cnt_nxt;
  logic [1:0]       beat_lo;

  assign selected  = !cs1_n_i && cs2_i && !cs3_n_i;
  assign start_a   = !strb_a_n_i && !cs1_n_i;
  assign start_b   = !strb_b_n_i;
  assign start_any = start_a || start_b;
  assign wr_mask   = !gwr_n_i ? {LANES{1'b1}} : (!bwr_n_i ? ~lane_sel_n_i : {LANES{1'b0}});
  assign wr_req    = |wr_mask;
  assign cnt_nxt   = adv_n_i ? cnt_q : cnt_q + 2'd1;
  assign beat_lo   = burst_offset(base_q[1:0], cnt_nxt, linear_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      base_q      <= '0;
      cnt_q       <= 2'd0;
      acc_vld_o   <= 1'b0;
      acc_wr_o    <= 1'b0;
      acc_desel_o <= 1'b0;
      acc_adv_o   <= 1'b0;
      acc_addr_o  <= '0;
      acc_mask_o  <= '0;
      acc_wdata_o <= '0;
    end else begin
      acc_vld_o   <= 1'b0;
      acc_wr_o    <= 1'b0;
      acc_desel_o <= 1'b0;
      acc_adv_o   <= 1'b0;
      if (!sleep_i) begin
        if (start_any) begin
          if (selected) begin
            active_q    <= 1'b1;
            base_q      <= addr_i;
            cnt_q       <= 2'd0;
            acc_vld_o   <= 1'b1;
            acc_wr_o    <= start_a ? 1'b0 : wr_req;
            acc_addr_o  <= addr_i;
            acc_mask_o  <= start_a ? {LANES{1'b0}} : wr_mask;
            acc_wdata_o <= wdata_i;
          end else begin
            active_q    <= 1'b0;
            acc_desel_o <= 1'b1;
          end
        end else if (active_q) begin
          cnt_q       <= cnt_nxt;
          acc_vld_o   <= 1'b1;
          acc_wr_o    <= wr_req;
          acc_adv_o   <= !adv_n_i;
          acc_addr_o  <= {base_q[ADDR_W-1:2], beat_lo};
          acc_mask_o  <= wr_mask;
          acc_wdata_o <= wdata_i;
        end
      end
    end
  end

endmodule

// File: rtl/sbs_mem_array.sv
`timescale 1ns/1ps
module sbs_mem_array #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [LANES-1:0]  wr_lanes_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANE_W = DATA_W / LANES;

  logic [DATA_W-1:0] bit_en;
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign bit_en[g*LANE_W +: LANE_W] = {LANE_W{wr_lanes_i[g]}};
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      mem[wr_addr_i] <= (mem[wr_addr_i] & ~bit_en) | (wr_data_i & bit_en);
    end
  end

  assign rd_data_o = mem[rd_addr_i];

endmodule

// File: rtl/sbs_out_stage.sv
`timescale 1ns/1ps
module sbs_out_stage #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode_i,
  input  logic              oe_n_i,
  input  logic              sleep_i,
  input  logic              rd_vld_i,
  input  logic              wr_busy_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              drive_o
);
  logic [DATA_W-1:0] q_data;
  logic              q_vld;
  logic [DATA_W-1:0] sel_data;
  logic              sel_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_vld  <= 1'b0;
      q_data <= '0;
    end else begin
      q_vld <= rd_vld_i;
      if (rd_vld_i) q_data <= rd_data_i;
    end
  end

  assign sel_vld  = pipe_mode_i ? q_vld  : rd_vld_i;
  assign sel_data = pipe_mode_i ? q_data : rd_data_i;
  assign drive_o  = sel_vld && !oe_n_i && !sleep_i && !wr_busy_i;
  assign dout_o   = drive_o ? sel_data : '0;

endmodule

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram #(
  parameter  int DATA_W = 36,
  parameter  int ADDR_W = 10,
  localparam int LANES  = sbs_pkg::lane_count(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              strb_a_n_i,
  input  logic              strb_b_n_i,
  input  logic              adv_n_i,
  input  logic              cs1_n_i,
  input  logic              cs2_i,
  input  logic              cs3_n_i,
  input  logic              gwr_n_i,
  input  logic              bwr_n_i,
  input  logic [LANES-1:0]  lane_sel_n_i,
  input  logic              oe_n_i,
  input  logic              sleep_i,
  input  logic              pipe_mode_i,
  input  logic              linear_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              drive_o
);
  // Input-stage events, named for the checker.
  logic              acc_vld;
  logic              acc_wr;
  logic              acc_desel;
  logic              acc_adv;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  acc_mask;
  logic [DATA_W-1:0] acc_wdata;
  logic [DATA_W-1:0] arr_rdata;
  logic              wr_fire;
  logic              rd_fire;

  assign wr_fire = acc_vld && acc_wr;
  assign rd_fire = acc_vld && !acc_wr;

  sbs_burst_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_i      (sleep_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .strb_a_n_i   (strb_a_n_i),
    .strb_b_n_i   (strb_b_n_i),
    .adv_n_i      (adv_n_i),
    .cs1_n_i      (cs1_n_i),
    .cs2_i        (cs2_i),
    .cs3_n_i      (cs3_n_i),
    .gwr_n_i      (gwr_n_i),
    .bwr_n_i      (bwr_n_i),
    .lane_sel_n_i (lane_sel_n_i),
    .linear_i     (linear_i),
    .acc_vld_o    (acc_vld),
    .acc_wr_o     (acc_wr),
    .acc_desel_o  (acc_desel),
    .acc_adv_o    (acc_adv),
    .acc_addr_o   (acc_addr),
    .acc_mask_o   (acc_mask),
    .acc_wdata_o  (acc_wdata)
  );

  sbs_mem_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANES(LANES)) u_mem (
    .clk        (clk),
    .wr_en_i    (wr_fire),
    .wr_addr_i  (acc_addr),
    .wr_lanes_i (acc_mask),
    .wr_data_i  (acc_wdata),
    .rd_addr_i  (acc_addr),
    .rd_data_o  (arr_rdata)
  );

  sbs_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .pipe_mode_i (pipe_mode_i),
    .oe_n_i      (oe_n_i),
    .sleep_i     (sleep_i),
    .rd_vld_i    (rd_fire),
    .wr_busy_i   (wr_fire),
    .rd_data_i   (arr_rdata),
    .dout_o      (dout_o),
    .drive_o     (drive_o)
  );

endmodule

// File: rtl/sync_burst_sram_chk.sv
`timescale 1ns/1ps
module sync_burst_sram_chk #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pipe_mode_i,
  input logic              linear_i,
  input logic              sleep_i,
  input logic              strb_a_n_i,
  input logic              cs1_n_i,
  input logic              gwr_n_i,
  input logic              drive_o,
  input logic              acc_vld,
  input logic              acc_wr,
  input logic              acc_desel,
  input logic              acc_adv,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [LANES-1:0]  acc_mask
);

  AST_DESEL_FLOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    acc_desel && !pipe_mode_i |-> !drive_o); // R9

  AST_DESEL_PIPE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    acc_desel && pipe_mode_i |=> !drive_o); // R9

  AST_SLEEP_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> !acc_vld && !acc_desel); // R14

  AST_STROBE_A_READS: assert property (@(posedge clk) disable iff (!rst_n)
    !strb_a_n_i && !cs1_n_i && !sleep_i |=> !acc_wr); // R3

  AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    !gwr_n_i && !sleep_i && strb_a_n_i |=> !acc_wr || (&acc_mask)); // R11

  AST_WRITE_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld && acc_wr |-> acc_mask != '0); // R10

  AST_BURST_HIGH_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_adv |-> acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2])); // R4

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_adv && linear_i |-> acc_addr[1:0] == $past(acc_addr[1:0]) + 2'd1); // R5

endmodule

bind sync_burst_sram sync_burst_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pipe_mode_i (pipe_mode_i),
  .linear_i    (linear_i),
  .sleep_i     (sleep_i),
  .strb_a_n_i  (strb_a_n_i),
  .cs1_n_i     (cs1_n_i),
  .gwr_n_i     (gwr_n_i),
  .drive_o     (drive_o),
  .acc_vld     (acc_vld),
  .acc_wr      (acc_wr),
  .acc_desel   (acc_desel),
  .acc_adv     (acc_adv),
  .acc_addr    (acc_addr),
  .acc_mask    (acc_mask)
);

// File: tb/sync_burst_sram_tb.sv
`timescale 1ns/1ps
module sync_burst_sram_tb;
  localparam int DW = 36;
  localparam int AW = 4;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DEPTH = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic          strb_a_n, strb_b_n, adv_n;
  logic          cs1_n, cs2, cs3_n;
  logic          gwr_n, bwr_n;
  logic [LN-1:0] lane_n;
  logic          oe_n, sleep, pipe, lin;
  logic [DW-1:0] dout;
  logic          drive;

  logic [DW-1:0] ref_mem [DEPTH];
  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  sync_burst_sram #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
    .strb_a_n_i(strb_a_n), .strb_b_n_i(strb_b_n), .adv_n_i(adv_n),
    .cs1_n_i(cs1_n), .cs2_i(cs2), .cs3_n_i(cs3_n),
    .gwr_n_i(gwr_n), .bwr_n_i(bwr_n), .lane_sel_n_i(lane_n),
    .oe_n_i(oe_n), .sleep_i(sleep), .pipe_mode_i(pipe), .linear_i(lin),
    .dout_o(dout), .drive_o(drive)
  );

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return DW'(a * 1103 + salt * 40503) ^ (DW'(salt) << 27) ^ 36'h9_A5C3_0F1E;
  endfunction

  task automatic chk_v(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s dout actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_b(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s drive actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    strb_a_n = 1'b1; strb_b_n = 1'b1; adv_n = 1'b1;
    cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0;
    gwr_n = 1'b1; bwr_n = 1'b1; lane_n = '1;
    addr = '0; wdata = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic deselect();
    idle(); strb_b_n = 1'b0; cs2 = 1'b0; tick();
    idle(); tick();
  endtask

  task automatic gwrite(input int a, input logic [DW-1:0] d);
    idle(); strb_b_n = 1'b0; addr = AW'(a); wdata = d; gwr_n = 1'b0; tick();
    ref_mem[a] = d;
    idle();
  endtask

  task automatic read_b(input int a);
    idle(); strb_b_n = 1'b0; addr = AW'(a); tick();
  endtask

  // Expected low address bits of burst beat c from start s.
  function automatic logic [1:0] beat(input int s, input int c, input logic linear);
    logic [1:0] sb, cb;
    sb = 2'(s); cb = 2'(c);
    if (linear) return 2'((s + c) % 4);
    return {sb[1] ^ cb[1], sb[0] ^ cb[0]};
  endfunction

  initial begin
    #(5.0 * 20000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    idle(); oe_n = 1'b0; sleep = 1'b0; pipe = 1'b1; lin = 1'b0; rst_n = 1'b0;
    repeat (3) tick();
    chk_b("R1", drive, 1'b0);
    chk_v("R1", dout, '0);
    rst_n = 1'b1;
    tick();
    chk_b("R1", drive, 1'b0);
    chk_v("R1", dout, '0);

    // Fill every word, one new address per cycle (R2)
    pipe = 1'b0;
    for (int a = 0; a < DEPTH; a++) gwrite(a, pat(a, 1));
    deselect();

    // Flow-through back-to-back reads (R7, R2)
    for (int a = 0; a < DEPTH; a++) begin
      read_b(a);
      chk_b("R7", drive, 1'b1);
      chk_v("R7", dout, ref_mem[a]);
    end
    deselect();

    // Pipelined back-to-back reads (R8)
    pipe = 1'b1; tick(); tick();
    for (int a = 0; a <= DEPTH; a++) begin
      idle();
      if (a < DEPTH) begin strb_b_n = 1'b0; addr = AW'(a); end
      tick();
      if (a == 0) chk_b("R8", drive, 1'b0);
      else begin
        chk_b("R8", drive, 1'b1);
        chk_v("R8", dout, ref_mem[a-1]);
      end
    end
    deselect();

    // Burst sweeps: both modes, both orders, every start offset (R4 R5 R6)
    for (int pm = 0; pm < 2; pm++) begin
      for (int ln = 0; ln < 2; ln++) begin
        for (int s = 0; s < 4; s++) begin
          pipe = pm[0]; lin = ln[0];
          tick(); tick();
          for (int c = 0; c < 5; c++) begin
            idle();
            if (c == 0) begin strb_a_n = 1'b0; addr = {2'b10, 2'(s)}; end
            else if (c < 4) adv_n = 1'b0;
            tick();
            if (pm == 0 && c < 4)
              chk_v(ln ? "R5" : "R6", dout, ref_mem[{2'b10, beat(s, c, ln[0])}]);
            if (pm == 1 && c >= 1)
              chk_v(ln ? "R5 R4" : "R6 R4", dout, ref_mem[{2'b10, beat(s, c - 1, ln[0])}]);
          end
          deselect();
        end
      end
    end

    // Hold without advance repeats the address (R4)
    pipe = 1'b0; lin = 1'b1; tick(); tick();
    idle(); strb_a_n = 1'b0; addr = 4'd6; tick();
    chk_v("R4", dout, ref_mem[6]);
    idle(); tick(); chk_v("R4", dout, ref_mem[6]);
    idle(); tick(); chk_v("R4", dout, ref_mem[6]);
    deselect();

    // Strobe A ignores write controls; A wins over B (R3)
    idle(); strb_a_n = 1'b0; addr = 4'd7; gwr_n = 1'b0; wdata = ~ref_mem[7]; tick();
    chk_b("R3", drive, 1'b1);
    chk_v("R3", dout, ref_mem[7]);
    idle(); strb_a_n = 1'b0; strb_b_n = 1'b0; addr = 4'd9; gwr_n = 1'b0; wdata = ~ref_mem[9]; tick();
    chk_b("R3", drive, 1'b1);
    chk_v("R3", dout, ref_mem[9]);
    deselect();
    read_b(7); chk_v("R3", dout, ref_mem[7]);
    read_b(9); chk_v("R3", dout, ref_mem[9]);
    deselect();
    // Strobe A with cs1_n high is ignored (R3)
    idle(); strb_a_n = 1'b0; cs1_n = 1'b1; addr = 4'd8; tick();
    chk_b("R3", drive, 1'b0);
    idle(); tick();
    chk_b("R3", drive, 1'b0);

    // Strobe B while unselected ends the session (R2)
    read_b(9); chk_b("R2", drive, 1'b1);
    idle(); strb_b_n = 1'b0; cs3_n = 1'b1; tick();
    chk_b("R2", drive, 1'b0);
    idle(); tick();
    chk_b("R2", drive, 1'b0);

    // Lane writes over all masks (R10, R12)
    for (int m = 0; m < 16; m++) begin
      logic [DW-1:0] d;
      d = pat(5, m + 2);
      idle(); strb_b_n = 1'b0; addr = 4'd5; bwr_n = 1'b0; lane_n = ~4'(m); wdata = d; tick();
      for (int l = 0; l < LN; l++) if (m[l]) ref_mem[5][l*LW +: LW] = d[l*LW +: LW];
      if (m != 0) chk_b("R12", drive, 1'b0);
      read_b(5);
      chk_v("R10", dout, ref_mem[5]);
    end
    idle(); strb_b_n = 1'b0; addr = 4'd5; lane_n = '0; wdata = pat(5, 99); tick();
    read_b(5);
    chk_v("R10", dout, ref_mem[5]);

    // Global write overrides lane controls (R11)
    idle(); strb_b_n = 1'b0; addr = 4'd11; gwr_n = 1'b0; bwr_n = 1'b0; lane_n = 4'b1110;
    wdata = pat(11, 7); tick();
    ref_mem[11] = pat(11, 7);
    read_b(11); chk_v("R11", dout, ref_mem[11]);
    idle(); strb_b_n = 1'b0; addr = 4'd11; gwr_n = 1'b0; wdata = pat(11, 8); tick();
    ref_mem[11] = pat(11, 8);
    read_b(11); chk_v("R11", dout, ref_mem[11]);
    deselect();

    // Deselect turn-off in flow-through (R9)
    read_b(3); chk_b("R9", drive, 1'b1);
    idle(); strb_b_n = 1'b0; cs2 = 1'b0; tick();
    chk_b("R9", drive, 1'b0);
    idle(); tick();

    // Deselect turn-off in pipelined mode (R9)
    pipe = 1'b1; tick(); tick();
    read_b(4); chk_b("R8", drive, 1'b0);
    idle(); strb_b_n = 1'b0; cs2 = 1'b0; tick();
    chk_b("R9", drive, 1'b1);
    chk_v("R9", dout, ref_mem[4]);
    idle(); tick();
    chk_b("R9", drive, 1'b0);

    // Write after pipelined read hides the pending data (R12)
    read_b(4);
    gwrite(12, pat(12, 5));
    chk_b("R12", drive, 1'b0);
    deselect();
    read_b(12); idle(); tick();
    chk_v("R12", dout, ref_mem[12]);
    deselect();

    // Output enable is asynchronous (R13)
    pipe = 1'b0; tick(); tick();
    read_b(2); chk_b("R13", drive, 1'b1);
    oe_n = 1'b1; #1;
    chk_b("R13", drive, 1'b0);
    chk_v("R13", dout, '0);
    oe_n = 1'b0; #1;
    chk_v("R13", dout, ref_mem[2]);

    // Sleep blocks access and keeps contents (R14)
    sleep = 1'b1; #1;
    chk_b("R14", drive, 1'b0);
    idle(); strb_b_n = 1'b0; addr = 4'd2; gwr_n = 1'b0; wdata = ~ref_mem[2]; tick(); tick();
    chk_b("R14", drive, 1'b0);
    idle(); sleep = 1'b0; tick();
    chk_b("R14", drive, 1'b1);
    chk_v("R14", dout, ref_mem[2]);
    deselect();
    read_b(2); chk_v("R14", dout, ref_mem[2]);
    deselect();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule